// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a 16-bit host write bus and a NOR-style flash array. It reads each bus write's low byte as a one-byte command. It keeps track of which source a read returns: array data, the status register, identifier data or query data. It also runs the multi-write sequences that start a word program, a block erase or a buffered program. An internal countdown timer stands in for the write state machine that would run the real program or erase algorithm. The timer reports completion after a fixed number of running cycles, and it can be frozen by a suspend and restarted by a resume.

While an operation runs, the controller accepts only a small set of commands and ignores every other write. An 8-bit status register reports the following:
- ready (bit 7)
- erase suspended (bit 6)
- erase or sequence error (bit 5)
- program or sequence error (bit 4)
- program suspended (bit 2)

Bits 3, 1 and 0 always read zero. The array, identifier and query contents come from input ports. The controller only selects among them and drives the result on `rd_data`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After a synchronous active-low reset the read source is the array, no operation is busy, and the status register holds 0x80.
- R2: While idle, command 0xFF selects array reads, which return all 16 bits of `array_data`. Command 0x90 selects identifier reads, which return all 16 bits of `id_data`. Command 0x70 selects status reads, which return `{8'h00, status}`. Command 0x98 selects query reads, which return `{8'h00, query_data}`.
- R3: While idle, any command value other than 0xFF, 0x70, 0x90, 0x98, 0x50, 0x40, 0x20 and 0xE8 is ignored: the read source and the status register are unchanged. This includes 0xD0 and 0xB0.
- R4: Command 0x40 followed by any write starts a program. That second write's address and data appear on `op_addr` and `op_data`, `op_is_erase` is 0, and reads switch to status. `op_busy` stays high for exactly OP_CYCLES cycles, and status bit 7 then returns to 1.
- R5: Command 0x20 followed by a write of 0xD0 starts an erase of the address given with the 0xD0 write, with `op_is_erase` high.
- R6: Command 0x20 followed by any value other than 0xD0 starts nothing. It sets status bits 5 and 4 and leaves reads on status.
- R7: While an operation is busy, status bit 7 reads 0. Only 0x70 and 0xB0 are accepted; every other write is ignored, including a change of read source.
- R8: Command 0xB0 while busy suspends the operation and freezes its timer. `op_busy` falls and status bit 7 is set, together with bit 2 for a program or bit 6 for an erase.
- R9: While suspended, 0xFF, 0x70, 0x90 and 0x98 change the read source, and all other commands are ignored except 0xD0. Command 0xD0 clears the suspend bit and resumes the operation, which then runs only for its remaining cycles.
- R10: A completion with `op_fail` high sets status bit 4 for a program or bit 5 for an erase. Error bits stay set until a 0x50 command is written while idle, which clears bits 5 and 4.
- R11: Command 0xE8 latches the start address. The next write carries a word count minus one in its data. A count minus one of BUF_WORDS or more sets bits 5 and 4 and aborts. Otherwise exactly count data writes are absorbed, whatever their values, and a following 0xD0 starts a program at the latched address. Any other confirm value sets bits 5 and 4 and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data; bits 7:0 carry the command |
| array_data | input | 16 | Array read source |
| id_data | input | 16 | Identifier read source |
| query_data | input | 8 | Query read source |
| op_fail | input | 1 | Failure flag sampled when an operation completes |
| rd_data | output | 16 | Read data from the selected source |
| op_busy | output | 1 | An operation is running (not suspended) |
| op_is_erase | output | 1 | The latched operation is an erase |
| op_addr | output | ADDR_W | Address of the latched operation |
| op_data | output | 16 | Data of the latched word program |

## Verification
The in-module assertions watch three things on every cycle. First, while an operation runs, a write other than 0x70 or 0xB0 leaves the read source, the status register and the busy state alone. Second, the two suspend bits are never set together, and error bits stay set unless an idle clear command arrives. Third, the timer holds its count while suspended and is active whenever the controller reports busy. Some behaviour can only be shown by the bench's scenarios. These are the exact busy length, including the remaining-cycle count after a suspend and resume, and the read values for every command byte in both the idle and busy states. They also include the buffered-program word counting with confirm-like data values and the status words left by bad confirms and failed completions.

// File: rtl/fci_pkg.sv
// Shared definitions for the flash command interface controller:
// read-source modes, sequencer states, command bytes and status bit positions.
package fci_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2,
        RD_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_PGM_SETUP   = 3'd1,
        ST_ERS_SETUP   = 3'd2,
        ST_BUF_COUNT   = 3'd3,
        ST_BUF_DATA    = 3'd4,
        ST_BUF_CONFIRM = 3'd5,
        ST_BUSY        = 3'd6,
        ST_SUSP        = 3'd7
    } seq_state_e;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_CLR_ERR   = 8'h50;
    localparam logic [7:0] CMD_PGM_WORD  = 8'h40;
    localparam logic [7:0] CMD_ERS_SETUP = 8'h20;
    localparam logic [7:0] CMD_PGM_BUF   = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND   = 8'hB0;

    localparam int SRB_READY    = 7;
    localparam int SRB_ERS_SUSP = 6;
    localparam int SRB_ERS_ERR  = 5;
    localparam int SRB_PGM_ERR  = 4;
    localparam int SRB_PGM_SUSP = 2;

endpackage

// File: rtl/fci_op_timer.sv
// Countdown stand-in for the write state machine.
// Loads OP_CYCLES on start, counts down once per cycle unless hold is high,
// and flags done in the cycle the count would leave 1.
// Assumes start is never raised while hold is high.
module fci_op_timer #(
    parameter int OP_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic active,
    output logic done
);
    localparam int TW = $clog2(OP_CYCLES + 1);

    logic [TW-1:0] cnt_q;

    // Load, hold or decrement the remaining-cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= TW'(OP_CYCLES);
        end else if (cnt_q != '0 && !hold) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign active = (cnt_q != '0);
    assign done   = (cnt_q == TW'(1)) && !hold;

    // R8: a suspended operation keeps its remaining count.
    assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !start) |=> $stable(cnt_q))
        else $error("timer moved while held");

endmodule

// File: rtl/fci_seq.sv
// Command sequencer and status register.
// Decodes the low byte of each bus write, walks the multi-write program, erase
// and buffered-program sequences, restricts commands while busy or suspended,
// and keeps the status bits. Assumes at most one write per cycle.
module fci_seq
    import fci_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int BUF_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              tmr_done,
    input  logic              op_fail,
    output rd_mode_e          rd_mode,
    output logic [7:0]        status,
    output logic              busy,
    output logic              suspended,
    output logic              tmr_start,
    output logic              op_is_erase,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data
);
    localparam int CNT_W = (BUF_WORDS > 2) ? $clog2(BUF_WORDS) : 1;

    seq_state_e        state_q;
    rd_mode_e          mode_q;
    logic              ers_susp_q, pgm_susp_q, ers_err_q, pgm_err_q;
    logic              kind_erase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       data_q;
    logic [CNT_W-1:0]  remain_q;
    logic [7:0]        cmd;
    logic              is_read_cmd;
    logic              count_bad;

    assign cmd         = wr_data[7:0];
    assign is_read_cmd = (cmd == CMD_RD_ARRAY) || (cmd == CMD_RD_STATUS) ||
                         (cmd == CMD_RD_IDENT) || (cmd == CMD_RD_QUERY);
    assign count_bad   = (32'(wr_data) >= BUF_WORDS);

    // Start the timer on the write that completes a valid sequence.
    always_comb begin
        tmr_start = 1'b0;
        if (wr_en) begin
            case (state_q)
                ST_PGM_SETUP:   tmr_start = 1'b1;
                ST_ERS_SETUP:   tmr_start = (cmd == CMD_CONFIRM);
                ST_BUF_CONFIRM: tmr_start = (cmd == CMD_CONFIRM);
                default:        tmr_start = 1'b0;
            endcase
        end
    end

    // Map a read-source command onto a mode.
    function automatic rd_mode_e mode_of(input logic [7:0] c, input rd_mode_e cur);
        case (c)
            CMD_RD_ARRAY:  return RD_ARRAY;
            CMD_RD_STATUS: return RD_STATUS;
            CMD_RD_IDENT:  return RD_IDENT;
            CMD_RD_QUERY:  return RD_QUERY;
            default:       return cur;
        endcase
    endfunction

    // Sequencer state, read mode, operation latch and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            mode_q       <= RD_ARRAY;
            ers_susp_q   <= 1'b0;
            pgm_susp_q   <= 1'b0;
            ers_err_q    <= 1'b0;
            pgm_err_q    <= 1'b0;
            kind_erase_q <= 1'b0;
            addr_q       <= '0;
            data_q       <= '0;
            remain_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (wr_en) begin
                    if (is_read_cmd) begin
                        mode_q <= mode_of(cmd, mode_q);
                    end else if (cmd == CMD_CLR_ERR) begin
                        ers_err_q <= 1'b0;
                        pgm_err_q <= 1'b0;
                    end else if (cmd == CMD_PGM_WORD) begin
                        state_q <= ST_PGM_SETUP;
                        mode_q  <= RD_STATUS;
                    end else if (cmd == CMD_ERS_SETUP) begin
                        state_q <= ST_ERS_SETUP;
                        mode_q  <= RD_STATUS;
                    end else if (cmd == CMD_PGM_BUF) begin
                        state_q <= ST_BUF_COUNT;
                        mode_q  <= RD_STATUS;
                        addr_q  <= wr_addr;
                    end
                end
                ST_PGM_SETUP: if (wr_en) begin
                    addr_q       <= wr_addr;
                    data_q       <= wr_data;
                    kind_erase_q <= 1'b0;
                    state_q      <= ST_BUSY;
                end
                ST_ERS_SETUP: if (wr_en) begin
                    if (cmd == CMD_CONFIRM) begin
                        addr_q       <= wr_addr;
                        kind_erase_q <= 1'b1;
                        state_q      <= ST_BUSY;
                    end else begin
                        ers_err_q <= 1'b1;
                        pgm_err_q <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_BUF_COUNT: if (wr_en) begin
                    if (count_bad) begin
                        ers_err_q <= 1'b1;
                        pgm_err_q <= 1'b1;
                        state_q   <= ST_IDLE;
                    end else begin
                        remain_q <= wr_data[CNT_W-1:0];
                        state_q  <= ST_BUF_DATA;
                    end
                end
                ST_BUF_DATA: if (wr_en) begin
                    data_q <= wr_data;
                    if (remain_q == '0) begin
                        state_q <= ST_BUF_CONFIRM;
                    end else begin
                        remain_q <= remain_q - CNT_W'(1);
                    end
                end
                ST_BUF_CONFIRM: if (wr_en) begin
                    if (cmd == CMD_CONFIRM) begin
                        kind_erase_q <= 1'b0;
                        state_q      <= ST_BUSY;
                    end else begin
                        ers_err_q <= 1'b1;
                        pgm_err_q <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_BUSY: begin
                    if (tmr_done) begin
                        state_q <= ST_IDLE;
                        if (op_fail) begin
                            if (kind_erase_q) ers_err_q <= 1'b1;
                            else              pgm_err_q <= 1'b1;
                        end
                    end else if (wr_en) begin
                        if (cmd == CMD_RD_STATUS) begin
                            mode_q <= RD_STATUS;
                        end else if (cmd == CMD_SUSPEND) begin
                            state_q <= ST_SUSP;
                            mode_q  <= RD_STATUS;
                            if (kind_erase_q) ers_susp_q <= 1'b1;
                            else              pgm_susp_q <= 1'b1;
                        end
                    end
                end
                ST_SUSP: if (wr_en) begin
                    if (is_read_cmd) begin
                        mode_q <= mode_of(cmd, mode_q);
                    end else if (cmd == CMD_CONFIRM) begin
                        ers_susp_q <= 1'b0;
                        pgm_susp_q <= 1'b0;
                        mode_q     <= RD_STATUS;
                        state_q    <= ST_BUSY;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q == ST_BUSY);
    assign suspended   = (state_q == ST_SUSP);
    assign rd_mode     = mode_q;
    assign op_is_erase = kind_erase_q;
    assign op_addr     = addr_q;
    assign op_data     = data_q;
    assign status      = {!busy, ers_susp_q, ers_err_q, pgm_err_q, 1'b0, pgm_susp_q, 2'b00};

    // R7: writes other than status-read and suspend leave a busy operation alone.
    assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !tmr_done && cmd != CMD_RD_STATUS && cmd != CMD_SUSPEND)
        |=> ($stable(mode_q) && $stable(status) && busy))
        else $error("busy operation disturbed by ignored write");

    // R8: program and erase suspend flags are never both set.
    assert_one_suspend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ers_susp_q, pgm_susp_q}))
        else $error("both suspend bits set");

    // R10: error bits persist until an idle clear command.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ers_err_q || pgm_err_q) && !(state_q == ST_IDLE && wr_en && cmd == CMD_CLR_ERR))
        |=> (ers_err_q || pgm_err_q))
        else $error("error bits dropped without clear");

    // R4: starting an operation leaves the block busy on status reads.
    assert_start_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> (busy && mode_q == RD_STATUS))
        else $error("start did not enter busy status mode");

endmodule

// File: rtl/fci_rd_mux.sv
// Read-data source selector: array, status, identifier or query data.
// Status and query are narrow sources and are returned zero-extended.
module fci_rd_mux
    import fci_pkg::*;
(
    input  rd_mode_e    rd_mode,
    input  logic [7:0]  status,
    input  logic [15:0] array_data,
    input  logic [15:0] id_data,
    input  logic [7:0]  query_data,
    output logic [15:0] rd_data
);
    // Pick the read source named by the current mode.
    always_comb begin
        case (rd_mode)
            RD_ARRAY:  rd_data = array_data;
            RD_STATUS: rd_data = {8'h00, status};
            RD_IDENT:  rd_data = id_data;
            RD_QUERY:  rd_data = {8'h00, query_data};
            default:   rd_data = array_data;
        endcase
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command interface controller top level.
// Ties the command sequencer to the operation timer and the read selector.
// Assumes the array, identifier and query sources are valid whenever selected.
module flash_cmd_ctrl
    import fci_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int BUF_WORDS = 512,
    parameter int OP_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [15:0]       array_data,
    input  logic [15:0]       id_data,
    input  logic [7:0]        query_data,
    input  logic              op_fail,
    output logic [15:0]       rd_data,
    output logic              op_busy,
    output logic              op_is_erase,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data
);
    rd_mode_e   rd_mode;
    logic [7:0] status;
    logic       suspended;
    logic       tmr_start, tmr_active, tmr_done;

    fci_seq #(
        .ADDR_W    (ADDR_W),
        .BUF_WORDS (BUF_WORDS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .tmr_done    (tmr_done),
        .op_fail     (op_fail),
        .rd_mode     (rd_mode),
        .status      (status),
        .busy        (op_busy),
        .suspended   (suspended),
        .tmr_start   (tmr_start),
        .op_is_erase (op_is_erase),
        .op_addr     (op_addr),
        .op_data     (op_data)
    );

    fci_op_timer #(
        .OP_CYCLES (OP_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .hold   (suspended),
        .active (tmr_active),
        .done   (tmr_done)
    );

    fci_rd_mux u_mux (
        .rd_mode    (rd_mode),
        .status     (status),
        .array_data (array_data),
        .id_data    (id_data),
        .query_data (query_data),
        .rd_data    (rd_data)
    );

    // R4: the sequencer never reports busy without a running timer.
    assert_busy_has_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |-> tmr_active)
        else $error("busy without active timer");

    // R9: a suspended operation keeps a nonzero remaining count.
    assert_susp_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> tmr_active)
        else $error("suspended with no remaining cycles");

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
    localparam int AW  = 8;
    localparam int BW  = 8;
    localparam int OPC = 8;
    localparam logic [15:0] ARR = 16'hA5C3;
    localparam logic [15:0] IDV = 16'h1234;
    localparam logic [7:0]  QRY = 8'h5E;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          op_fail = 1'b0;
    logic [15:0]   rd_data;
    logic          op_busy, op_is_erase;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .BUF_WORDS(BW), .OP_CYCLES(OPC)) u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .array_data(ARR), .id_data(IDV), .query_data(QRY), .op_fail(op_fail),
        .rd_data(rd_data), .op_busy(op_busy), .op_is_erase(op_is_erase),
        .op_addr(op_addr), .op_data(op_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Counts busy samples from the current negedge until idle.
    task automatic run_out(output int n);
        n = 0;
        while (op_busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] idle_expect(input logic [7:0] c);
        case (c)
            8'hFF:   return ARR;
            8'h70:   return 16'h0080;
            8'h90:   return IDV;
            8'h98:   return {8'h00, QRY};
            default: return ARR;
        endcase
    endfunction

    initial begin
        #(10 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == ARR, "R1 array after reset", rd_data, ARR);
        chk(!op_busy, "R1 idle after reset", op_busy, 0);
        wr(0, 16'h0070);
        chk(rd_data == 16'h0080, "R1 status after reset", rd_data, 16'h0080);

        // R2 / R3 sweep over every command byte while idle
        for (int c = 0; c < 256; c++) begin
            if (c == 8'h40 || c == 8'h20 || c == 8'hE8) continue;
            wr(0, 16'h00FF);
            wr(8'h11, {8'hA0, 8'(c)});
            chk(rd_data == idle_expect(8'(c)), (c == 8'hFF || c == 8'h70 || c == 8'h90 || c == 8'h98) ?
                "R2 read source" : "R3 ignored command", rd_data, idle_expect(8'(c)));
            wr(0, 16'h0070);
            chk(rd_data == 16'h0080 && !op_busy, "R3 status untouched", rd_data, 16'h0080);
        end

        // R4 word program
        wr(0, 16'h0040);
        wr(8'h3C, 16'hBEEF);
        chk(op_busy && op_addr == 8'h3C && op_data == 16'hBEEF && !op_is_erase,
            "R4 program latch", {op_busy, op_is_erase, op_addr, op_data}, {2'b10, 8'h3C, 16'hBEEF});
        chk(rd_data == 16'h0000, "R7 ready low while busy", rd_data, 16'h0000);
        run_out(n);
        chk(n == OPC, "R4 busy length", n, OPC);
        chk(rd_data == 16'h0080, "R4 ready after done", rd_data, 16'h0080);

        // R5 erase
        wr(0, 16'h0020);
        wr(8'h51, 16'h00D0);
        chk(op_busy && op_is_erase && op_addr == 8'h51, "R5 erase start",
            {op_busy, op_is_erase, op_addr}, {2'b11, 8'h51});
        run_out(n);
        chk(n == OPC, "R5 erase length", n, OPC);

        // R6 bad erase confirm, R10 clear
        wr(0, 16'h0020);
        wr(0, 16'h00FF);
        chk(rd_data == 16'h00B0 && !op_busy, "R6 bad confirm", rd_data, 16'h00B0);
        wr(0, 16'h0070);
        chk(rd_data == 16'h00B0, "R10 error sticky", rd_data, 16'h00B0);
        wr(0, 16'h0050);
        chk(rd_data == 16'h0080, "R10 clear", rd_data, 16'h0080);

        // R7 sweep of every command byte while busy (suspend excluded)
        for (int c = 0; c < 256; c++) begin
            if (c == 8'hB0) continue;
            wr(0, 16'h0040);
            wr(8'h02, 16'h1111);
            wr(0, {8'h00, 8'(c)});
            chk(op_busy && rd_data == 16'h0000, "R7 busy ignores", rd_data, 16'h0000);
            run_out(n);
            chk(rd_data == 16'h0080, "R7 mode kept after busy", rd_data, 16'h0080);
        end

        // R8 / R9 program suspend and resume
        wr(0, 16'h0040);
        wr(8'h07, 16'h2222);
        wr(0, 16'h00B0);
        chk(!op_busy && rd_data == 16'h0084, "R8 program suspend", rd_data, 16'h0084);
        wr(0, 16'h00FF);
        chk(rd_data == ARR, "R9 read array while suspended", rd_data, ARR);
        wr(0, 16'h0040);
        chk(rd_data == ARR && !op_busy, "R9 other command ignored", rd_data, ARR);
        wr(0, 16'h0070);
        chk(rd_data == 16'h0084, "R9 still suspended", rd_data, 16'h0084);
        repeat (5) @(negedge clk);
        wr(0, 16'h00D0);
        chk(op_busy && rd_data == 16'h0000, "R9 resume", rd_data, 16'h0000);
        run_out(n);
        chk(n == OPC - 2, "R9 remaining cycles", n, OPC - 2);
        chk(rd_data == 16'h0080, "R9 done after resume", rd_data, 16'h0080);

        // R8 erase suspend
        wr(0, 16'h0020);
        wr(8'h09, 16'h00D0);
        wr(0, 16'h00B0);
        chk(!op_busy && rd_data == 16'h00C0, "R8 erase suspend", rd_data, 16'h00C0);
        wr(0, 16'h0098);
        chk(rd_data == {8'h00, QRY}, "R9 query while suspended", rd_data, {8'h00, QRY});
        wr(0, 16'h00D0);
        run_out(n);
        chk(n == OPC - 2 && rd_data == 16'h0080, "R9 erase resume", {n[15:0], rd_data}, {16'(OPC - 2), 16'h0080});

        // R10 failure reporting
        op_fail = 1'b1;
        wr(0, 16'h0040);
        wr(0, 16'h3333);
        run_out(n);
        chk(rd_data == 16'h0090, "R10 program fail", rd_data, 16'h0090);
        wr(0, 16'h0050);
        wr(0, 16'h0020);
        wr(0, 16'h00D0);
        run_out(n);
        chk(rd_data == 16'h00A0, "R10 erase fail", rd_data, 16'h00A0);
        op_fail = 1'b0;
        wr(0, 16'h0050);
        chk(rd_data == 16'h0080, "R10 clear after fail", rd_data, 16'h0080);

        // R11 buffered program
        wr(8'h77, 16'h00E8);
        wr(0, 16'd3);
        for (int k = 0; k < 4; k++) wr(0, 16'h00D0);
        chk(!op_busy, "R11 data not confirm", op_busy, 0);
        wr(0, 16'h00D0);
        chk(op_busy && op_addr == 8'h77 && !op_is_erase, "R11 buffer start", {op_busy, op_addr}, {1'b1, 8'h77});
        run_out(n);
        chk(n == OPC, "R11 buffer length", n, OPC);
        wr(8'h10, 16'h00E8);
        wr(0, 16'(BW));
        chk(rd_data == 16'h00B0 && !op_busy, "R11 count too large", rd_data, 16'h00B0);
        wr(0, 16'h0050);
        wr(8'h20, 16'h00E8);
        wr(0, 16'(BW - 1));
        for (int k = 0; k < BW; k++) wr(0, 16'h00D0);
        wr(0, 16'h00D0);
        chk(op_busy && op_addr == 8'h20, "R11 max count", {op_busy, op_addr}, {1'b1, 8'h20});
        run_out(n);
        wr(0, 16'h00E8);
        wr(0, 16'd0);
        wr(0, 16'h4444);
        wr(0, 16'h00FF);
        chk(rd_data == 16'h00B0 && !op_busy, "R11 bad confirm", rd_data, 16'h00B0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule